// File: doc/BRIEF.md
# MN+A Programmable RF Divider

This block divides a stream of input events by a programmable ratio. A dual-modulus counter stage counts 16 or 17 events per step, and a 13-bit main count M sets how many steps make up one division. A 4-bit swallow count A sets how many of the leading steps use the longer modulus of 17. The total ratio is therefore 16·M + A. An optional divide-by-two stage in front of the counters doubles the ratio.

Each completed division produces a single-cycle comparison pulse. An end-of-division strobe marks the clock edge at which the ratio and prescaler inputs are reloaded, so a new setting takes effect only at a division boundary. A divided-by-two copy of the comparison output is provided for observation on a test pin.

The controller has three named states. LOAD is entered on reset and captures the configuration. SWALLOW counts steps of 17 events while the swallow count is non-zero. MAIN counts steps of 16 events. The transitions are:
- LOAD→SWALLOW when A is non-zero, and LOAD→MAIN when A is zero.
- SWALLOW→MAIN when the last swallow step completes before the division ends.
- SWALLOW or MAIN → SWALLOW/MAIN, chosen by the new A, on the final event of a division.

Top module: `mnadiv_top`

## Requirements
- R1: While reset is active, div_pulse_o, eoc_o and div_half_o are 0. The first clock after reset release captures the configuration, and an event presented on that clock is not counted.
- R2: With pre_en_i = 0, M ≥ 1 and A ≤ M, one comparison pulse is produced per 16·M + A accepted events. When A > M, the ratio is 17·M.
- R3: With pre_en_i = 1, the ratio is twice the R2 value in input events.
- R4: div_pulse_o is high for exactly one cycle. It rises in the cycle after the clock edge that accepts the final event of a division.
- R5: eoc_o is high exactly in the cycle in which the final event of a division is presented on ev_i, which is the cycle before div_pulse_o.
- R6: ratio_m_i and ratio_a_i are sampled only on the edge where eoc_o is high (or the first edge after reset). A change at any other time does not alter the running division.
- R7: A new ratio presented in the same cycle as eoc_o governs the very next division.
- R8: div_half_o is 0 after reset and inverts on each comparison pulse, and only then.
- R9: Cycles with ev_i low do not advance the count, and eoc_o is never high while ev_i is low.
- R10: A change of pre_en_i in the middle of a division takes effect only from the next division.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 1 | Input event, one per cycle when high |
| pre_en_i | input | 1 | 1 inserts the divide-by-two stage |
| ratio_m_i | input | 13 | Main count M |
| ratio_a_i | input | 4 | Swallow count A |
| div_pulse_o | output | 1 | One-cycle comparison pulse per division |
| eoc_o | output | 1 | End-of-division strobe (reload edge) |
| div_half_o | output | 1 | Comparison output divided by two |

## Verification
The final event of a division and a change of the ratio inputs can land in the same cycle. The bench provokes this by altering M and A at the moment eoc_o is seen high. It then judges the result by counting events to the following pulse, which must match the new ratio and not the old one. A second coincidence occurs when the last swallow step and the last main step end together (A = M, or A > M). The bench covers this with ratios that hit that case and compares the measured event count against 16·M plus the effective swallow count.

// File: rtl/mnadiv_pkg.sv
package mnadiv_pkg;
    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_SWALLOW = 2'd1,
        ST_MAIN    = 2'd2
    } div_state_e;
endpackage

// File: rtl/mnadiv_prescale.sv
module mnadiv_prescale (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic sel,
    input  logic ev,
    output logic pev
);
    logic phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase_q <= 1'b0;
        else if (!run || !sel)
            phase_q <= 1'b0;
        else if (ev)
            phase_q <= ~phase_q;
    end

    assign pev = run && ev && (!sel || phase_q);
endmodule

// File: rtl/mnadiv_modcnt.sv
module mnadiv_modcnt #(
    parameter int A_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic step,
    input  logic ext,
    output logic wrap
);
    localparam int P_W = A_W + 1;
    localparam int N   = 1 << A_W;

    logic [P_W-1:0] cnt_q;
    logic [P_W-1:0] top;

    assign top  = ext ? P_W'(N) : P_W'(N - 1);
    assign wrap = step && (cnt_q == top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= wrap ? '0 : cnt_q + P_W'(1);
    end
endmodule

// File: rtl/mnadiv_downcnt.sv
module mnadiv_downcnt #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         is_one
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - W'(1);
    end

    assign is_one = (cnt_q == W'(1));
endmodule

// File: rtl/mnadiv_top.sv
module mnadiv_top
    import mnadiv_pkg::*;
#(
    parameter int M_W = 13,
    parameter int A_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_i,
    input  logic           pre_en_i,
    input  logic [M_W-1:0] ratio_m_i,
    input  logic [A_W-1:0] ratio_a_i,
    output logic           div_pulse_o,
    output logic           eoc_o,
    output logic           div_half_o
);
    div_state_e state_q, state_nx;
    logic run, reload, last, pev, wrap, m_one, a_one, pre_sel_q;
    logic pulse_q, half_q;

    assign run    = (state_q != ST_LOAD);
    assign last   = wrap && m_one;
    assign reload = !run || last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pre_sel_q <= 1'b0;
        else if (reload)
            pre_sel_q <= pre_en_i;
    end

    mnadiv_prescale u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(pre_sel_q),
        .ev(ev_i), .pev(pev)
    );

    mnadiv_modcnt #(.A_W(A_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .clr(!run), .step(pev),
        .ext(state_q == ST_SWALLOW), .wrap(wrap)
    );

    mnadiv_downcnt #(.W(M_W)) u_mcnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .load_val(ratio_m_i),
        .dec(wrap && !last), .is_one(m_one)
    );

    mnadiv_downcnt #(.W(A_W)) u_acnt (
        .clk(clk), .rst_n(rst_n), .load(reload), .load_val(ratio_a_i),
        .dec(wrap && !last && (state_q == ST_SWALLOW)), .is_one(a_one)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_LOAD;
        else
            state_q <= state_nx;
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_LOAD:
                state_nx = (ratio_a_i != '0) ? ST_SWALLOW : ST_MAIN;
            ST_SWALLOW:
                if (last)
                    state_nx = (ratio_a_i != '0) ? ST_SWALLOW : ST_MAIN;
                else if (wrap && a_one)
                    state_nx = ST_MAIN;
            ST_MAIN:
                if (last)
                    state_nx = (ratio_a_i != '0) ? ST_SWALLOW : ST_MAIN;
            default:
                state_nx = ST_LOAD;
        endcase
    end

    // output process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            half_q  <= 1'b0;
        end else begin
            pulse_q <= last;
            if (last)
                half_q <= ~half_q;
        end
    end

    assign eoc_o       = last;
    assign div_pulse_o = pulse_q;
    assign div_half_o  = half_q;
endmodule

// File: rtl/mnadiv_chk.sv
module mnadiv_chk (
    input logic clk,
    input logic rst_n,
    input logic ev_i,
    input logic div_pulse_o,
    input logic eoc_o,
    input logic div_half_o
);
    always @(posedge clk) begin
        if (!rst_n)
            assert_reset_quiet_R1: assert (!div_pulse_o && !eoc_o && !div_half_o);
    end

    assert_pulse_narrow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);

    assert_eoc_leads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> div_pulse_o);

    assert_pulse_after_eoc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |-> $past(eoc_o));

    assert_half_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |-> (div_half_o != $past(div_half_o)));

    assert_half_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !div_pulse_o |-> $stable(div_half_o));

    assert_idle_no_eoc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_i |-> !eoc_o);
endmodule

bind mnadiv_top mnadiv_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i),
    .div_pulse_o(div_pulse_o), .eoc_o(eoc_o), .div_half_o(div_half_o)
);

// File: tb/tb_mnadiv_top.sv
`timescale 1ns/1ps
module tb_mnadiv_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ev = 1'b0;
    logic        pre_en = 1'b0;
    logic [12:0] rm = 13'd1;
    logic [3:0]  ra = 4'd0;
    logic        div_pulse, eoc, div_half;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mnadiv_top dut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev), .pre_en_i(pre_en),
        .ratio_m_i(rm), .ratio_a_i(ra),
        .div_pulse_o(div_pulse), .eoc_o(eoc), .div_half_o(div_half)
    );

    typedef struct packed {
        logic        pre;
        logic [12:0] m;
        logic [3:0]  a;
        logic [7:0]  gap;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 13'd1,   4'd0,  8'd0},
        '{1'b0, 13'd1,   4'd1,  8'd0},
        '{1'b0, 13'd5,   4'd3,  8'd0},
        '{1'b0, 13'd15,  4'd15, 8'd0},
        '{1'b0, 13'd100, 4'd7,  8'd0},
        '{1'b1, 13'd2,   4'd2,  8'd0},
        '{1'b1, 13'd3,   4'd0,  8'd0},
        '{1'b0, 13'd2,   4'd5,  8'd2},
        '{1'b1, 13'd4,   4'd2,  8'd1}
    };

    function automatic int ratio_f(logic p, logic [12:0] mm, logic [3:0] aa);
        int ae;
        ae = (int'(aa) < int'(mm)) ? int'(aa) : int'(mm);
        return (p ? 2 : 1) * (16 * int'(mm) + ae);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        ev = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // mode: 0 none, 1 change at sample chg_s, 2 change when eoc seen
    task automatic run_case(input logic p, input logic [12:0] mm, input logic [3:0] aa,
                            input int gap, input int nper, input int mode, input int chg_s,
                            input logic np, input logic [12:0] nm, input logic [3:0] na,
                            input string tag);
        int exp_r, cnt, seen, samp, gcnt;
        bit prev_eoc, prev_pulse, half_exp, done;
        pre_en = p; rm = mm; ra = aa;
        do_reset();
        exp_r = ratio_f(p, mm, aa);
        cnt = 0; seen = 0; samp = 0; gcnt = 0;
        prev_eoc = 0; prev_pulse = 0; half_exp = 0; done = 0;
        while (seen < nper && samp < 30000) begin
            @(negedge clk);
            samp++;
            if (ev) cnt++;
            if (div_pulse) begin
                chk(cnt == exp_r, tag, cnt, exp_r);
                chk(prev_eoc, "R5", int'(prev_eoc), 1);
                chk(!prev_pulse, "R4", int'(prev_pulse), 0);
                half_exp = ~half_exp;
                chk(div_half == half_exp, "R8", int'(div_half), int'(half_exp));
                cnt = 0;
                exp_r = ratio_f(pre_en, rm, ra);
                seen++;
            end else if (prev_eoc) begin
                chk(1'b0, "R5", 0, 1);
            end
            prev_pulse = div_pulse;
            ev = (gcnt == 0);
            gcnt = (gcnt >= gap) ? 0 : gcnt + 1;
            #1;
            prev_eoc = eoc;
            if (!ev && eoc) chk(1'b0, "R9", 1, 0);
            if (!done && ((mode == 1 && samp == chg_s) || (mode == 2 && eoc))) begin
                pre_en = np; rm = nm; ra = na;
                done = 1;
            end
        end
        chk(seen == nper, tag, seen, nper);
        ev = 1'b0;
    endtask

    initial begin
        #(150000 * 20);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet in reset, even with events presented
        rst_n = 1'b0;
        ev = 1'b1;
        repeat (3) @(negedge clk);
        chk(!div_pulse, "R1", int'(div_pulse), 0);
        chk(!eoc, "R1", int'(eoc), 0);
        chk(!div_half, "R1", int'(div_half), 0);

        // vector table: R2, R3, R9
        foreach (VECS[i]) begin
            string tg;
            tg = (VECS[i].gap != 0) ? "R9" : (VECS[i].pre ? "R3" : "R2");
            run_case(VECS[i].pre, VECS[i].m, VECS[i].a, int'(VECS[i].gap), 3,
                     0, 0, 1'b0, 13'd1, 4'd0, tg);
        end

        // R1: event on the first clock after reset is not counted
        begin
            int s;
            pre_en = 1'b0; rm = 13'd1; ra = 4'd0;
            rst_n = 1'b0;
            ev = 1'b1;
            repeat (2) @(negedge clk);
            rst_n = 1'b1;
            s = 0;
            while (!div_pulse && s < 100) begin
                @(negedge clk);
                s++;
            end
            chk(s == 17, "R1", s, 17);
            ev = 1'b0;
        end

        // R6: ratio change mid-division, then later divisions use it
        run_case(1'b0, 13'd2, 4'd0, 0, 3, 1, 5, 1'b0, 13'd3, 4'd1, "R6");
        // R10: prescaler select changed mid-division
        run_case(1'b0, 13'd2, 4'd0, 0, 3, 1, 5, 1'b1, 13'd2, 4'd0, "R10");
        // R7: change in the same cycle as the end strobe
        run_case(1'b0, 13'd1, 4'd0, 0, 2, 2, 0, 1'b0, 13'd6, 4'd5, "R7");
        // R7 with gapped events and the prescaler
        run_case(1'b1, 13'd1, 4'd1, 1, 2, 2, 0, 1'b0, 13'd2, 4'd2, "R7");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule